// File: doc/BRIEF.md
# Physical Memory Protection Permission Checker

This block decides whether one memory access may go ahead under a set of protection regions. Each region arrives already decoded as an inclusive byte range (low and high bound) plus an 8-bit configuration byte. For each access the block takes the address, the size in bytes, whether the requester runs in machine mode, and the requested read/write/execute bits. It returns the granted read/write/execute mask and an allow flag one clock later.

Regions are scanned with a fixed priority, index 0 first. An access that covers only part of a region is refused outright. Three policy inputs shape the result: one that turns the whole check on, a lockdown mode that changes how region permissions are read, and a whitelist mode that refuses any access no region matches. The decision is combinational. A two-process register stage holds the response.

Top module: `pmp_perm_check`

## Requirements
- R1: Configuration byte layout: bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the match mode and bit 7 is the lock. A region whose match mode is 0 (off) never matches and never causes a partial-overlap refusal, even when its bounds cover the access.
- R2: Among active regions that hold both the first byte and the last byte of the access, the one with the lowest index decides the grant. Regions with higher indices have no effect.
- R3: Regions are scanned from index 0 upward. At the first active region that holds exactly one of the first and last byte, the grant is 000 and allow is 0, whatever later regions hold.
- R4: The last byte is address + size - 1. A size of 0 is handled as a 4-byte access (ADDR_W/8 bytes).
- R5: With lockdown clear, a matching region grants RWX to a machine-mode access when its lock bit is 0. In every other case the grant is the region's own R, W and X bits.
- R6: With lockdown set and a machine-mode access, a matching region's index {L,R,W,X} (L is the most significant bit) gives: RW for 2, 3, 14; X for 9, 10; RX for 11, 13; R for 12, 15; nothing for every other index.
- R7: With lockdown set and a lower-mode access, the index {L,R,W,X} gives: X for 1, 10, 11; R for 2, 4, 15; RW for 3, 6; RX for 5; RWX for 7; nothing for 0, 8, 9, 12, 13, 14.
- R8: When no region matches: with whitelist set the grant is 000. Otherwise, with lockdown set, a machine-mode access that does not request execute gets RW and every other access gets 000. Otherwise machine mode gets RWX and lower modes get 000.
- R9: When the check is turned off, every access gets RWX and allow is 1.
- R10: allow is 1 exactly when every requested bit is present in the granted mask.
- R11: A request sampled on one rising edge shows its response (valid, grant, allow) after that edge. The response valid follows the request valid with one cycle of delay. Reset clears valid, grant and allow to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_en | input | 1 | 1 = protection check on; 0 = grant all |
| lockdown | input | 1 | Machine-mode lockdown policy |
| whitelist | input | 1 | Refuse accesses that match no region |
| rgn_lo | input | NUM_RGN*ADDR_W | Inclusive low byte bound of each region |
| rgn_hi | input | NUM_RGN*ADDR_W | Inclusive high byte bound of each region |
| rgn_cfg | input | NUM_RGN*8 | Configuration byte of each region |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Access start byte address |
| req_size | input | SIZE_W | Access size in bytes; 0 means one word |
| req_mach | input | 1 | 1 = machine mode, 0 = lower mode |
| req_rwx | input | 3 | Requested access, bit 0 read, bit 1 write, bit 2 execute |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 3 | Granted mask, same bit order as req_rwx |
| rsp_allow | output | 1 | Request is fully covered by the grant |

## Verification
The assertions assume that region bounds, configuration bytes and the policy inputs stay stable while a request is being sampled. They also assume that the lower bound of each region does not exceed its upper bound, since the decoding stage upstream guarantees this. The stimulus only changes configuration on the falling edge and always writes well-formed ranges. It keeps sizes small enough that the last byte does not wrap past the top of the address space, so first-byte and last-byte tests stay meaningful.

// File: rtl/pmp_perm_pkg.sv
package pmp_perm_pkg;

    // Configuration byte field positions
    localparam int unsigned CFG_R_BIT = 0;
    localparam int unsigned CFG_W_BIT = 1;
    localparam int unsigned CFG_X_BIT = 2;
    localparam int unsigned CFG_M_LSB = 3;
    localparam int unsigned CFG_L_BIT = 7;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RANGE = 2'd1,
        MODE_FOUR  = 2'd2,
        MODE_POW2  = 2'd3
    } match_mode_e;

    // Registered response; grant bit order {X,W,R}
    typedef struct packed {
        logic       valid;
        logic [2:0] grant;
        logic       allow;
    } rsp_t;

    // Lockdown truth tables, idx = {L,R,W,X}
    function automatic logic [2:0] lockdown_grant(input logic mach, input logic [3:0] idx);
        logic [2:0] g;
        g = 3'b000;
        if (mach) begin
            case (idx)
                4'd2, 4'd3, 4'd14: g = 3'b011;
                4'd9, 4'd10:       g = 3'b100;
                4'd11, 4'd13:      g = 3'b101;
                4'd12, 4'd15:      g = 3'b001;
                default:           g = 3'b000;
            endcase
        end else begin
            case (idx)
                4'd1, 4'd10, 4'd11: g = 3'b100;
                4'd2, 4'd4, 4'd15:  g = 3'b001;
                4'd3, 4'd6:         g = 3'b011;
                4'd5:               g = 3'b101;
                4'd7:               g = 3'b111;
                default:            g = 3'b000;
            endcase
        end
        return g;
    endfunction

endpackage

// File: rtl/pmp_rgn_match.sv
module pmp_rgn_match #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              active_i,
    input  logic [ADDR_W-1:0] lo_i,
    input  logic [ADDR_W-1:0] hi_i,
    input  logic [ADDR_W-1:0] first_i,
    input  logic [ADDR_W-1:0] last_i,
    output logic              full_o,
    output logic              part_o
);
    logic first_in;
    logic last_in;

    always_comb begin
        first_in = (first_i >= lo_i) && (first_i <= hi_i);
        last_in  = (last_i  >= lo_i) && (last_i  <= hi_i);
        full_o   = active_i && first_in && last_in;
        part_o   = active_i && (first_in ^ last_in);
    end
endmodule

// File: rtl/pmp_prio_pick.sv
module pmp_prio_pick #(
    parameter int unsigned NUM_RGN = 8,
    localparam int unsigned IDX_W  = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_RGN-1:0] full_i,
    input  logic [NUM_RGN-1:0] part_i,
    output logic [IDX_W-1:0]   sel_o,
    output logic               hit_o,
    output logic               partial_o
);
    logic found;
    logic sel_part;

    // Scan from the top down so the lowest index overwrites last
    always_comb begin
        found    = 1'b0;
        sel_part = 1'b0;
        sel_o    = '0;
        for (int i = NUM_RGN - 1; i >= 0; i--) begin
            if (full_i[i] || part_i[i]) begin
                found    = 1'b1;
                sel_part = part_i[i];
                sel_o    = IDX_W'(i);
            end
        end
        hit_o     = found && !sel_part;
        partial_o = found && sel_part;
    end

    // R2
    winner_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (full_i[sel_o] && ((full_i & ((NUM_RGN'(1) << sel_o) - NUM_RGN'(1))) == '0)));

    // R3
    winner_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
        partial_o |-> (part_i[sel_o] && ((part_i & ((NUM_RGN'(1) << sel_o) - NUM_RGN'(1))) == '0)));
endmodule

// File: rtl/pmp_grant_calc.sv
module pmp_grant_calc
    import pmp_perm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chk_en_i,
    input  logic       lockdown_i,
    input  logic       whitelist_i,
    input  logic       mach_i,
    input  logic [2:0] rwx_i,
    input  logic       hit_i,
    input  logic       partial_i,
    input  logic [3:0] lrwx_i,
    output logic [2:0] grant_o,
    output logic       allow_o
);
    logic [2:0] own_bits;
    logic       locked;

    always_comb begin
        locked   = lrwx_i[3];
        own_bits = {lrwx_i[0], lrwx_i[1], lrwx_i[2]};
        grant_o  = 3'b000;
        if (!chk_en_i) begin
            grant_o = 3'b111;
        end else if (partial_i) begin
            grant_o = 3'b000;
        end else if (hit_i) begin
            if (lockdown_i) begin
                grant_o = lockdown_grant(mach_i, lrwx_i);
            end else if (mach_i && !locked) begin
                grant_o = 3'b111;
            end else begin
                grant_o = own_bits;
            end
        end else if (whitelist_i) begin
            grant_o = 3'b000;
        end else if (lockdown_i) begin
            grant_o = (mach_i && !rwx_i[2]) ? 3'b011 : 3'b000;
        end else begin
            grant_o = mach_i ? 3'b111 : 3'b000;
        end
        allow_o = ((rwx_i & ~grant_o) == 3'b000);
    end

    // R8
    whitelist_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en_i && whitelist_i && !hit_i && !partial_i) |-> (grant_o == 3'b000));

    // R8
    lockdown_noexec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_en_i && lockdown_i && !hit_i) |-> !grant_o[2]);
endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
    import pmp_perm_pkg::*;
#(
    parameter int unsigned NUM_RGN = 8,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SIZE_W  = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        chk_en,
    input  logic                        lockdown,
    input  logic                        whitelist,
    input  logic [NUM_RGN*ADDR_W-1:0]   rgn_lo,
    input  logic [NUM_RGN*ADDR_W-1:0]   rgn_hi,
    input  logic [NUM_RGN*8-1:0]        rgn_cfg,
    input  logic                        req_valid,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [SIZE_W-1:0]           req_size,
    input  logic                        req_mach,
    input  logic [2:0]                  req_rwx,
    output logic                        rsp_valid,
    output logic [2:0]                  rsp_grant,
    output logic                        rsp_allow
);
    localparam int unsigned IDX_W      = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1;
    localparam int unsigned WORD_BYTES = ADDR_W / 8;

    logic [7:0]         cfg_arr [NUM_RGN];
    logic [NUM_RGN-1:0] full_v;
    logic [NUM_RGN-1:0] part_v;
    logic [NUM_RGN-1:0] cfg_unused;
    logic [SIZE_W-1:0]  eff_size;
    logic [ADDR_W-1:0]  last_byte;
    logic [IDX_W-1:0]   sel_idx;
    logic               any_hit;
    logic               any_part;
    logic [3:0]         sel_lrwx;
    logic [2:0]         calc_grant;
    logic               calc_allow;
    rsp_t               rsp_d;
    rsp_t               rsp_q;

    always_comb begin
        eff_size  = (req_size == '0) ? SIZE_W'(WORD_BYTES) : req_size;
        last_byte = req_addr + ADDR_W'(eff_size) - ADDR_W'(1);
    end

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        logic rgn_active;
        assign cfg_arr[g]    = rgn_cfg[g*8 +: 8];
        assign rgn_active    = (match_mode_e'(cfg_arr[g][CFG_M_LSB +: 2]) != MODE_OFF);
        assign cfg_unused[g] = ^cfg_arr[g][6:5];

        pmp_rgn_match #(.ADDR_W(ADDR_W)) u_match (
            .active_i (rgn_active),
            .lo_i     (rgn_lo[g*ADDR_W +: ADDR_W]),
            .hi_i     (rgn_hi[g*ADDR_W +: ADDR_W]),
            .first_i  (req_addr),
            .last_i   (last_byte),
            .full_o   (full_v[g]),
            .part_o   (part_v[g])
        );
    end

    pmp_prio_pick #(.NUM_RGN(NUM_RGN)) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_i    (full_v),
        .part_i    (part_v),
        .sel_o     (sel_idx),
        .hit_o     (any_hit),
        .partial_o (any_part)
    );

    always_comb begin
        sel_lrwx = {cfg_arr[sel_idx][CFG_L_BIT], cfg_arr[sel_idx][CFG_R_BIT],
                    cfg_arr[sel_idx][CFG_W_BIT], cfg_arr[sel_idx][CFG_X_BIT]};
    end

    pmp_grant_calc u_calc (
        .clk         (clk),
        .rst_n       (rst_n),
        .chk_en_i    (chk_en),
        .lockdown_i  (lockdown),
        .whitelist_i (whitelist),
        .mach_i      (req_mach),
        .rwx_i       (req_rwx),
        .hit_i       (any_hit),
        .partial_i   (any_part),
        .lrwx_i      (sel_lrwx),
        .grant_o     (calc_grant),
        .allow_o     (calc_allow)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.grant = calc_grant;
            rsp_d.allow = calc_allow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_grant = rsp_q.grant;
    assign rsp_allow = rsp_q.allow;

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R11
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3
    partial_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_en && (part_v != '0) && ((full_v & ~part_v) == '0)) |=>
            (rsp_grant == 3'b000 && !rsp_allow));

    // R10
    allow_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_allow == (($past(req_rwx) & ~rsp_grant) == 3'b000)));

    // R9
    disabled_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !chk_en) |=> (rsp_grant == 3'b111 && rsp_allow));
endmodule

// File: tb/pmp_perm_check_test.sv
`timescale 1ns/1ps
module pmp_perm_check_test;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int SW = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            chk_en = 1'b0;
    logic            lockdown = 1'b0;
    logic            whitelist = 1'b0;
    logic [N*AW-1:0] rgn_lo;
    logic [N*AW-1:0] rgn_hi;
    logic [N*8-1:0]  rgn_cfg;
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [SW-1:0]   req_size = '0;
    logic            req_mach = 1'b0;
    logic [2:0]      req_rwx = '0;
    logic            rsp_valid;
    logic [2:0]      rsp_grant;
    logic            rsp_allow;

    logic [AW-1:0]   e_lo  [N];
    logic [AW-1:0]   e_hi  [N];
    logic [7:0]      e_cfg [N];
    logic [2:0]      tab_m [16];
    logic [2:0]      tab_u [16];

    logic [2:0]      q_grant [$];
    logic            q_allow [$];
    string           q_tag   [$];

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rgn_lo[i*AW +: AW] = e_lo[i];
            rgn_hi[i*AW +: AW] = e_hi[i];
            rgn_cfg[i*8 +: 8]  = e_cfg[i];
        end
    end

    pmp_perm_check #(.NUM_RGN(N), .ADDR_W(AW), .SIZE_W(SW)) uut (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .lockdown(lockdown),
        .whitelist(whitelist), .rgn_lo(rgn_lo), .rgn_hi(rgn_hi), .rgn_cfg(rgn_cfg),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .req_mach(req_mach), .req_rwx(req_rwx), .rsp_valid(rsp_valid),
        .rsp_grant(rsp_grant), .rsp_allow(rsp_allow)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Independent reference: returns {allow, grant[2:0]}
    function automatic logic [3:0] model(input logic [AW-1:0] a, input logic [SW-1:0] sz,
                                         input logic m, input logic [2:0] rwx);
        logic [2:0]    g;
        logic [AW-1:0] lst;
        logic          decided;
        g = 3'b000;
        decided = 1'b0;
        if (!chk_en) begin
            g = 3'b111;
            decided = 1'b1;
        end
        lst = a + ((sz == 0) ? AW'(4) : AW'(sz)) - AW'(1);
        for (int i = 0; i < N; i++) begin
            if (!decided && e_cfg[i][4:3] != 2'b00) begin
                logic fi, li;
                fi = (a >= e_lo[i]) && (a <= e_hi[i]);
                li = (lst >= e_lo[i]) && (lst <= e_hi[i]);
                if (fi != li) begin
                    g = 3'b000;
                    decided = 1'b1;
                end else if (fi && li) begin
                    logic [3:0] ix;
                    ix = {e_cfg[i][7], e_cfg[i][0], e_cfg[i][1], e_cfg[i][2]};
                    if (lockdown)             g = m ? tab_m[ix] : tab_u[ix];
                    else if (m && !ix[3])     g = 3'b111;
                    else                      g = e_cfg[i][2:0];
                    decided = 1'b1;
                end
            end
        end
        if (!decided) begin
            if (whitelist)     g = 3'b000;
            else if (lockdown) g = (m && !rwx[2]) ? 3'b011 : 3'b000;
            else               g = m ? 3'b111 : 3'b000;
        end
        return {((rwx & ~g) == 3'b000), g};
    endfunction

    task automatic issue(input logic [AW-1:0] a, input logic [SW-1:0] sz,
                         input logic m, input logic [2:0] rwx, input string tag);
        logic [3:0] e;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_size  = sz;
        req_mach  = m;
        req_rwx   = rwx;
        e = model(a, sz, m, rwx);
        q_grant.push_back(e[2:0]);
        q_allow.push_back(e[3]);
        q_tag.push_back(tag);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_rgn();
        for (int i = 0; i < N; i++) begin
            e_lo[i] = '0; e_hi[i] = '0; e_cfg[i] = 8'h00;
        end
    endtask

    // Monitor: compare responses against the scoreboard queue
    always @(posedge clk) begin
        #1;
        if (rst_n && rsp_valid) begin
            if (q_tag.size() == 0) begin
                check(1'b0, "R11 unexpected response", 32'(rsp_valid), 32'h0);
            end else begin
                logic [2:0] eg;
                logic       ea;
                string      t;
                eg = q_grant.pop_front();
                ea = q_allow.pop_front();
                t  = q_tag.pop_front();
                check(rsp_grant == eg, {t, " grant"}, 32'(rsp_grant), 32'(eg));
                check(rsp_allow == ea, {t, " allow"}, 32'(rsp_allow), 32'(ea));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tab_m = '{3'b000,3'b000,3'b011,3'b011,3'b000,3'b000,3'b000,3'b000,
                  3'b000,3'b100,3'b100,3'b101,3'b001,3'b101,3'b011,3'b001};
        tab_u = '{3'b000,3'b100,3'b001,3'b011,3'b001,3'b101,3'b011,3'b111,
                  3'b000,3'b000,3'b100,3'b100,3'b000,3'b000,3'b000,3'b001};
        clear_rgn();
        repeat (3) @(negedge clk);
        // R11 reset state
        check(rsp_valid == 1'b0, "R11 reset valid", 32'(rsp_valid), 32'h0);
        check(rsp_grant == 3'b000, "R11 reset grant", 32'(rsp_grant), 32'h0);
        check(rsp_allow == 1'b0, "R11 reset allow", 32'(rsp_allow), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 check turned off
        issue(32'h100, 12'd4, 1'b0, 3'b111, "R9 off lower");
        issue(32'h9000, 12'd8, 1'b1, 3'b100, "R9 off machine");
        idle(1);
        chk_en = 1'b1;

        // R8 no active regions, plain policy
        issue(32'h40, 12'd4, 1'b1, 3'b111, "R8 empty machine");
        issue(32'h40, 12'd4, 1'b0, 3'b001, "R8 empty lower");

        // R1 off region covering the access is skipped
        e_lo[0] = 32'h000; e_hi[0] = 32'hFFF; e_cfg[0] = 8'h00;
        e_lo[1] = 32'h100; e_hi[1] = 32'h1FF; e_cfg[1] = 8'h09; // mode 1, R
        issue(32'h180, 12'd4, 1'b0, 3'b001, "R1 off skipped read");
        issue(32'h180, 12'd4, 1'b0, 3'b010, "R1 off skipped write");
        idle(1);

        // R2 priority: region0 read-only inside region1 RWX
        clear_rgn();
        e_lo[0] = 32'h100; e_hi[0] = 32'h1FF; e_cfg[0] = 8'h09;
        e_lo[1] = 32'h000; e_hi[1] = 32'hFFF; e_cfg[1] = 8'h1F;
        issue(32'h100, 12'd4, 1'b0, 3'b001, "R2 low wins read");
        issue(32'h100, 12'd4, 1'b0, 3'b010, "R10 low wins write denied");
        issue(32'h300, 12'd4, 1'b0, 3'b110, "R2 second region RWX");
        // R3 partial overlap of region0 refused though region1 covers
        issue(32'h1FE, 12'd4, 1'b0, 3'b001, "R3 partial tail");
        issue(32'h0FE, 12'd4, 1'b1, 3'b001, "R3 partial head");
        // R4 size zero is a word
        issue(32'h1FC, 12'd0, 1'b0, 3'b001, "R4 size0 fits");
        issue(32'h1FE, 12'd0, 1'b0, 3'b001, "R4 size0 partial");
        issue(32'h1FE, 12'd1, 1'b0, 3'b001, "R4 size1 fits");
        // R5 machine unlocked gets RWX, locked gets own bits
        issue(32'h120, 12'd4, 1'b1, 3'b110, "R5 machine unlocked");
        idle(1);
        e_cfg[0] = 8'h89;
        issue(32'h120, 12'd4, 1'b1, 3'b001, "R5 machine locked read");
        issue(32'h120, 12'd4, 1'b1, 3'b100, "R5 machine locked exec");
        idle(1);

        // R6 R7 lockdown truth tables
        clear_rgn();
        lockdown = 1'b1;
        e_lo[0] = 32'h100; e_hi[0] = 32'h1FF;
        for (int ix = 0; ix < 16; ix++) begin
            idle(0);
            e_cfg[0] = {ix[3], 2'b00, 2'b01, ix[0], ix[1], ix[2]};
            issue(32'h104, 12'd4, 1'b1, 3'b001, $sformatf("R6 idx %0d", ix));
            issue(32'h104, 12'd4, 1'b0, 3'b001, $sformatf("R7 idx %0d", ix));
        end

        // R8 miss under lockdown and whitelist
        issue(32'h800, 12'd4, 1'b1, 3'b011, "R8 lockdown machine rw");
        issue(32'h800, 12'd4, 1'b1, 3'b100, "R8 lockdown machine exec");
        issue(32'h800, 12'd4, 1'b0, 3'b001, "R8 lockdown lower");
        idle(1);
        whitelist = 1'b1;
        issue(32'h800, 12'd4, 1'b1, 3'b001, "R8 whitelist machine");
        idle(3);

        // R11 valid drops when idle and all responses drained
        check(rsp_valid == 1'b0, "R11 idle valid", 32'(rsp_valid), 32'h0);
        check(q_tag.size() == 0, "R11 all answered", 32'(q_tag.size()), 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule